// File: doc/BRIEF.md
# Flash Command Launch Sequencer

This block drives a single command into a flash controller that is reached through memory-mapped registers. A pulse on `start` captures a command code, a flash target address, a data word and a space flag (program or data space). The block then runs the whole launch on its own. It waits for the controller to report that any earlier command has finished, prepares the controller with a fixed list of register writes, and stores the data word into the flash array. It then writes the command code, launches the command and waits for it to complete.

The register side is a simple master port. A read or write request, with its address and write data, is held until the slave raises `bus_ready` for one cycle. Writes to the flash array go out on a second port that uses the same handshake and also carries the space flag. When the sequence ends, the block raises `done` for one cycle. At that point it presents the last status word read, an execution-error flag taken from the protection-violation and access-error bits, and a timeout flag. Each completion-polling phase has its own read watchdog.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, and whenever no command is in progress, `busy`, `done`, `bus_rd`, `bus_wr` and `arr_wr` are low, and `final_status`, `exec_err` and `timeout` are zero until the first command ends.
- R2: After `start`, the block reads the status register (REG_BASE+OFF_STAT) repeatedly. It issues no write until a read returns bit 6 (value 0x40, "complete") set.
- R3: Each polling phase allows at most POLL_LIMIT (100) status reads. A phase whose 100th read shows bit 6 set succeeds. A phase with 100 reads and bit 6 clear ends with a timeout.
- R4: The preparation writes are issued in this order, one at a time: configuration register 0x00, status register 0x04, status register 0x10, status register 0x20, protection register 0x00, secondary protection register 0x00.
- R5: After the preparation writes, the data word is written on the array port to the target address, with `arr_prog` equal to the captured space flag. The command code is then written to the command register.
- R6: The command is launched by writing 0x80 to the status register. The block then polls the status register again until bit 6 is set.
- R7: At the end of a run, `done` is high for exactly one cycle and `busy` falls. `final_status` holds the value of the last status read.
- R8: `exec_err` is set at `done` when the final status has bit 5 (0x20, protection violation) or bit 4 (0x10, access error) set, and the run did not time out.
- R9: A timeout in the first polling phase ends the run at once, with `timeout` set. No register or array write is issued and the command is not launched.
- R10: `start` is ignored while a command is in progress.
- R11: At most one of `bus_rd`, `bus_wr` and `arr_wr` is high at a time. Each request keeps its address and data stable until its ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a command launch (ignored while busy) |
| cmd_code | input | CMD_W | Command code to issue |
| tgt_addr | input | ADDR_W | Flash array address for the data word |
| tgt_data | input | DATA_W | Data word written to the array |
| space_prog | input | 1 | 1 = program space, 0 = data space |
| busy | output | 1 | A command is in progress |
| bus_rd | output | 1 | Register read request |
| bus_wr | output | 1 | Register write request |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | DATA_W | Register write data |
| bus_rdata | input | DATA_W | Register read data, valid with bus_ready |
| bus_ready | input | 1 | Register transfer complete |
| arr_wr | output | 1 | Array write request |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| arr_prog | output | 1 | Space flag for the array write |
| arr_ready | input | 1 | Array write complete |
| done | output | 1 | One-cycle end-of-run pulse |
| final_status | output | DATA_W | Last status word read |
| exec_err | output | 1 | Protection-violation or access-error seen |
| timeout | output | 1 | A polling phase ran out of reads |

## Verification
The assertions assume that `bus_ready` and `arr_ready` rise only while the matching request is pending, and that each stays high for exactly one cycle per transfer. The request-hold and one-request-at-a-time properties rely on this. The bench's responder follows these rules: it raises ready only after it has seen a request, optionally after a set number of wait cycles, and drops it on the next cycle. Its status model counts busy reads in each phase separately, so the bench controls exactly where a phase completes or runs out. This is how it reaches the 99-busy and 100-busy limits.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_POLL_REQ,
    S_POLL_WAIT,
    S_STEP_REQ,
    S_STEP_WAIT,
    S_FINISH
  } seq_state_t;

  typedef enum logic [2:0] {
    D_CFG,
    D_STAT,
    D_PROT,
    D_PROTB,
    D_CMD,
    D_ARRAY
  } dest_t;

  localparam int STEP_COUNT = 9;
  localparam int STEP_W     = $clog2(STEP_COUNT);
  localparam int DONE_BIT   = 6;
  localparam int ERR_MASK   = 'h30;
  localparam int LAUNCH_VAL = 'h80;

endpackage

// File: rtl/fcs_step_rom.sv
module fcs_step_rom
  import fcs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CMD_W  = 8
) (
  input  logic [STEP_W-1:0] step,
  input  logic [CMD_W-1:0]  cmd_code,
  output dest_t             dest,
  output logic [DATA_W-1:0] value,
  output logic              last
);

  always_comb begin
    dest  = D_CFG;
    value = '0;
    unique case (step)
      STEP_W'(0): begin dest = D_CFG;   value = '0; end
      STEP_W'(1): begin dest = D_STAT;  value = DATA_W'('h04); end
      STEP_W'(2): begin dest = D_STAT;  value = DATA_W'('h10); end
      STEP_W'(3): begin dest = D_STAT;  value = DATA_W'('h20); end
      STEP_W'(4): begin dest = D_PROT;  value = '0; end
      STEP_W'(5): begin dest = D_PROTB; value = '0; end
      STEP_W'(6): begin dest = D_ARRAY; value = '0; end
      STEP_W'(7): begin dest = D_CMD;   value = DATA_W'(cmd_code); end
      STEP_W'(8): begin dest = D_STAT;  value = DATA_W'(LAUNCH_VAL); end
      default:    begin dest = D_CFG;   value = '0; end
    endcase
  end

  assign last = (step == STEP_W'(STEP_COUNT - 1));

endmodule

// File: rtl/fcs_poll_timer.sv
module fcs_poll_timer #(
  parameter int POLL_LIMIT = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  output logic last_read
);

  localparam int CNT_W = $clog2(POLL_LIMIT + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (tick)  cnt <= cnt + 1'b1;
  end

  assign last_read = (cnt == CNT_W'(POLL_LIMIT - 1));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 16,
  parameter int CMD_W      = 8,
  parameter int REG_BASE   = 'hF400,
  parameter int OFF_CFG    = 'h01,
  parameter int OFF_PROT   = 'h10,
  parameter int OFF_PROTB  = 'h11,
  parameter int OFF_STAT   = 'h13,
  parameter int OFF_CMD    = 'h14,
  parameter int POLL_LIMIT = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CMD_W-1:0]  cmd_code,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [DATA_W-1:0] tgt_data,
  input  logic              space_prog,
  output logic              busy,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ready,
  output logic              arr_wr,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              arr_prog,
  input  logic              arr_ready,
  output logic              done,
  output logic [DATA_W-1:0] final_status,
  output logic              exec_err,
  output logic              timeout
);

  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(REG_BASE + OFF_CFG);
  localparam logic [ADDR_W-1:0] A_PROT  = ADDR_W'(REG_BASE + OFF_PROT);
  localparam logic [ADDR_W-1:0] A_PROTB = ADDR_W'(REG_BASE + OFF_PROTB);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(REG_BASE + OFF_STAT);
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(REG_BASE + OFF_CMD);
  localparam logic [DATA_W-1:0] ERR_BITS = DATA_W'(ERR_MASK);

  seq_state_t          state;
  logic [STEP_W-1:0]   step;
  logic [CMD_W-1:0]    cmd_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   data_q;
  logic                space_q;
  logic                launched;
  logic                to_q;
  logic [DATA_W-1:0]   stat_q;

  dest_t               step_dest;
  logic [DATA_W-1:0]   step_val;
  logic                step_last;
  logic [ADDR_W-1:0]   step_addr;
  logic                poll_last;
  logic                step_ack;
  logic                timer_clr;
  logic                timer_tick;

  fcs_step_rom #(.DATA_W(DATA_W), .CMD_W(CMD_W)) u_rom (
    .step     (step),
    .cmd_code (cmd_q),
    .dest     (step_dest),
    .value    (step_val),
    .last     (step_last)
  );

  always_comb begin
    unique case (step_dest)
      D_CFG:   step_addr = A_CFG;
      D_STAT:  step_addr = A_STAT;
      D_PROT:  step_addr = A_PROT;
      D_PROTB: step_addr = A_PROTB;
      D_CMD:   step_addr = A_CMD;
      default: step_addr = A_CFG;
    endcase
  end

  assign step_ack   = (bus_wr && bus_ready) || (arr_wr && arr_ready);
  assign timer_tick = (state == S_POLL_WAIT) && bus_ready;
  assign timer_clr  = (state == S_IDLE) ||
                      ((state == S_STEP_WAIT) && step_ack && step_last);

  fcs_poll_timer #(.POLL_LIMIT(POLL_LIMIT)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .clr       (timer_clr),
    .tick      (timer_tick),
    .last_read (poll_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      step         <= '0;
      cmd_q        <= '0;
      addr_q       <= '0;
      data_q       <= '0;
      space_q      <= 1'b0;
      launched     <= 1'b0;
      to_q         <= 1'b0;
      stat_q       <= '0;
      busy         <= 1'b0;
      bus_rd       <= 1'b0;
      bus_wr       <= 1'b0;
      bus_addr     <= '0;
      bus_wdata    <= '0;
      arr_wr       <= 1'b0;
      arr_addr     <= '0;
      arr_wdata    <= '0;
      arr_prog     <= 1'b0;
      done         <= 1'b0;
      final_status <= '0;
      exec_err     <= 1'b0;
      timeout      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            cmd_q    <= cmd_code;
            addr_q   <= tgt_addr;
            data_q   <= tgt_data;
            space_q  <= space_prog;
            launched <= 1'b0;
            to_q     <= 1'b0;
            busy     <= 1'b1;
            bus_rd   <= 1'b1;
            bus_addr <= A_STAT;
            state    <= S_POLL_WAIT;
          end
        end
        S_POLL_REQ: begin
          bus_rd   <= 1'b1;
          bus_addr <= A_STAT;
          state    <= S_POLL_WAIT;
        end
        S_POLL_WAIT: begin
          if (bus_ready) begin
            bus_rd <= 1'b0;
            stat_q <= bus_rdata;
            if (bus_rdata[DONE_BIT]) begin
              if (launched) begin
                state <= S_FINISH;
              end else begin
                step  <= '0;
                state <= S_STEP_REQ;
              end
            end else if (poll_last) begin
              to_q  <= 1'b1;
              state <= S_FINISH;
            end else begin
              state <= S_POLL_REQ;
            end
          end
        end
        S_STEP_REQ: begin
          if (step_dest == D_ARRAY) begin
            arr_wr    <= 1'b1;
            arr_addr  <= addr_q;
            arr_wdata <= data_q;
            arr_prog  <= space_q;
          end else begin
            bus_wr    <= 1'b1;
            bus_addr  <= step_addr;
            bus_wdata <= step_val;
          end
          state <= S_STEP_WAIT;
        end
        S_STEP_WAIT: begin
          if (step_ack) begin
            bus_wr <= 1'b0;
            arr_wr <= 1'b0;
            if (step_last) begin
              launched <= 1'b1;
              state    <= S_POLL_REQ;
            end else begin
              step  <= step + 1'b1;
              state <= S_STEP_REQ;
            end
          end
        end
        S_FINISH: begin
          done         <= 1'b1;
          busy         <= 1'b0;
          final_status <= stat_q;
          timeout      <= to_q;
          exec_err     <= !to_q && ((stat_q & ERR_BITS) != '0);
          state        <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
  parameter int ADDR_W   = 24,
  parameter int REG_BASE = 'hF400,
  parameter int OFF_STAT = 'h13
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ready,
  input logic              arr_wr,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              arr_ready,
  input logic              done,
  input logic              exec_err,
  input logic              timeout
);

  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_BASE + OFF_STAT);

  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bus_rd, bus_wr, arr_wr}));                                   // R11
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((bus_rd || bus_wr) && !bus_ready) |=> ((bus_rd || bus_wr) && $stable(bus_addr))); // R11
  AST_ARR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (arr_wr && !arr_ready) |=> (arr_wr && $stable(arr_addr)));            // R11
  AST_READ_STATUS: assert property (@(posedge clk) disable iff (rst)
    bus_rd |-> (bus_addr == A_STAT));                                      // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!bus_rd && !bus_wr && !arr_wr));                            // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                                       // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);                                                       // R7
  AST_TIMEOUT_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    !(timeout && exec_err));                                               // R8

endmodule

bind flash_cmd_seq fcs_checker #(
  .ADDR_W   (ADDR_W),
  .REG_BASE (REG_BASE),
  .OFF_STAT (OFF_STAT)
) u_fcs_checker (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_ready (bus_ready),
  .arr_wr    (arr_wr),
  .arr_addr  (arr_addr),
  .arr_ready (arr_ready),
  .done      (done),
  .exec_err  (exec_err),
  .timeout   (timeout)
);

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;

  localparam int AW = 24;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam int BASE = 'hF400;
  localparam logic [AW-1:0] T_CFG   = AW'(BASE + 'h01);
  localparam logic [AW-1:0] T_PROT  = AW'(BASE + 'h10);
  localparam logic [AW-1:0] T_PROTB = AW'(BASE + 'h11);
  localparam logic [AW-1:0] T_STAT  = AW'(BASE + 'h13);
  localparam logic [AW-1:0] T_CMD   = AW'(BASE + 'h14);
  localparam int LIMIT = 100;

  typedef struct packed {
    logic [7:0]  cmd;
    logic [23:0] addr;
    logic [15:0] data;
    logic        space;
    logic [7:0]  pre_busy;
    logic [7:0]  post_busy;
    logic [15:0] fin;
    logic [1:0]  lat;
    logic        exp_err;
    logic        exp_to;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    {8'h20, 24'h000400, 16'hA5C3, 1'b1, 8'd0,   8'd3,   16'h0040, 2'd0, 1'b0, 1'b0},
    {8'h40, 24'h0012FE, 16'h1234, 1'b0, 8'd5,   8'd0,   16'h0020, 2'd1, 1'b1, 1'b0},
    {8'h41, 24'h00FFFF, 16'hFFFF, 1'b1, 8'd2,   8'd7,   16'h0010, 2'd2, 1'b1, 1'b0},
    {8'h05, 24'h000001, 16'h0000, 1'b0, 8'd99,  8'd1,   16'h0004, 2'd0, 1'b0, 1'b0},
    {8'h20, 24'h000200, 16'h5555, 1'b1, 8'd100, 8'd0,   16'h0040, 2'd0, 1'b0, 1'b1},
    {8'h66, 24'h003000, 16'h8001, 1'b0, 8'd1,   8'd100, 16'h0040, 2'd1, 1'b0, 1'b1},
    {8'h10, 24'h00ABCD, 16'h0F0F, 1'b1, 8'd0,   8'd99,  16'h0030, 2'd0, 1'b1, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [CW-1:0] cmd_code = '0;
  logic [AW-1:0] tgt_addr = '0;
  logic [DW-1:0] tgt_data = '0;
  logic          space_prog = 1'b0;
  logic          busy, bus_rd, bus_wr, arr_wr, arr_prog, done, exec_err, timeout;
  logic [AW-1:0] bus_addr, arr_addr;
  logic [DW-1:0] bus_wdata, arr_wdata, final_status;
  logic [DW-1:0] bus_rdata = '0;
  logic          bus_ready = 1'b0;
  logic          arr_ready = 1'b0;

  always #10 clk = ~clk;

  flash_cmd_seq #(
    .ADDR_W(AW), .DATA_W(DW), .CMD_W(CW), .REG_BASE(BASE),
    .OFF_CFG('h01), .OFF_PROT('h10), .OFF_PROTB('h11),
    .OFF_STAT('h13), .OFF_CMD('h14), .POLL_LIMIT(LIMIT)
  ) dut (
    .clk(clk), .rst(rst), .start(start), .cmd_code(cmd_code),
    .tgt_addr(tgt_addr), .tgt_data(tgt_data), .space_prog(space_prog),
    .busy(busy), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .arr_wr(arr_wr), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .arr_prog(arr_prog), .arr_ready(arr_ready), .done(done),
    .final_status(final_status), .exec_err(exec_err), .timeout(timeout)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // responder model state
  int pre_busy, post_busy, lat;
  logic [DW-1:0] fin_val;
  int pre_seen, post_seen, bus_wait, arr_wait;
  bit launched_m;
  int nreads, nwrites, reads_at_first_wr;
  logic [AW-1:0] w_addr [16];
  logic [DW-1:0] w_data [16];
  bit            w_arr  [16];
  bit            w_prog [16];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic log_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input bit is_arr, input bit pg);
    if (nwrites == 0) reads_at_first_wr = nreads;
    if (nwrites < 16) begin
      w_addr[nwrites] = a;
      w_data[nwrites] = d;
      w_arr[nwrites]  = is_arr;
      w_prog[nwrites] = pg;
    end
    nwrites++;
  endtask

  always @(negedge clk) begin
    if (rst) begin
      bus_ready = 1'b0;
      arr_ready = 1'b0;
    end else begin
      if ((bus_rd || bus_wr) && !bus_ready) begin
        if (bus_wait >= lat) begin
          bus_wait = 0;
          bus_ready = 1'b1;
          if (bus_rd) begin
            nreads++;
            if (!launched_m) begin
              if (pre_seen < pre_busy) begin bus_rdata = '0; pre_seen++; end
              else bus_rdata = 16'h0040;
            end else begin
              if (post_seen < post_busy) begin bus_rdata = '0; post_seen++; end
              else bus_rdata = fin_val | 16'h0040;
            end
          end else begin
            log_write(bus_addr, bus_wdata, 1'b0, 1'b0);
            if (bus_addr == T_STAT && bus_wdata == 16'h0080) launched_m = 1'b1;
          end
        end else bus_wait++;
      end else bus_ready = 1'b0;

      if (arr_wr && !arr_ready) begin
        if (arr_wait >= lat) begin
          arr_wait = 0;
          arr_ready = 1'b1;
          log_write(arr_addr, arr_wdata, 1'b1, arr_prog);
        end else arr_wait++;
      end else arr_ready = 1'b0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic clear_model(input vec_t v);
    pre_busy = int'(v.pre_busy);
    post_busy = int'(v.post_busy);
    fin_val = v.fin;
    lat = int'(v.lat);
    pre_seen = 0; post_seen = 0; bus_wait = 0; arr_wait = 0;
    launched_m = 1'b0;
    nreads = 0; nwrites = 0; reads_at_first_wr = -1;
  endtask

  task automatic launch(input vec_t v, input int hold);
    @(negedge clk);
    cmd_code = v.cmd; tgt_addr = v.addr; tgt_data = v.data; space_prog = v.space;
    start = 1'b1;
    repeat (hold) @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic run_vec(input vec_t v, input int hold);
    bit seen;
    int exp_reads;
    logic [AW-1:0] ea [9];
    logic [DW-1:0] ed [9];
    clear_model(v);
    launch(v, hold);
    wait_done(seen);
    chk(seen, "R7 done seen", 32'(seen), 1);
    chk(!busy, "R7 busy low at done", 32'(busy), 0);
    chk(timeout == v.exp_to, "R3 timeout flag", 32'(timeout), 32'(v.exp_to));
    chk(exec_err == v.exp_err, "R8 exec_err", 32'(exec_err), 32'(v.exp_err));
    if (v.exp_to)
      chk(final_status == 16'h0000, "R7 final status on timeout", 32'(final_status), 0);
    else
      chk(final_status == (v.fin | 16'h0040), "R7 final status",
          32'(final_status), 32'(v.fin | 16'h0040));
    if (v.pre_busy >= LIMIT) begin
      chk(nreads == LIMIT, "R9 reads before timeout", 32'(nreads), LIMIT);
      chk(nwrites == 0, "R9 no writes after pre timeout", 32'(nwrites), 0);
    end else begin
      exp_reads = int'(v.pre_busy) + 1 +
                  ((v.post_busy >= LIMIT) ? LIMIT : int'(v.post_busy) + 1);
      chk(nreads == exp_reads, "R3 R6 total status reads", 32'(nreads), 32'(exp_reads));
      chk(reads_at_first_wr == int'(v.pre_busy) + 1, "R2 writes wait for complete",
          32'(reads_at_first_wr), 32'(int'(v.pre_busy) + 1));
      chk(nwrites == 9, "R4 write count", 32'(nwrites), 9);
      ea = '{T_CFG, T_STAT, T_STAT, T_STAT, T_PROT, T_PROTB, v.addr, T_CMD, T_STAT};
      ed = '{16'h0000, 16'h0004, 16'h0010, 16'h0020, 16'h0000, 16'h0000,
             v.data, 16'(v.cmd), 16'h0080};
      for (int k = 0; k < 9; k++) begin
        chk(w_addr[k] == ea[k], (k < 6) ? "R4 write address" : "R5 R6 write address",
            32'(w_addr[k]), 32'(ea[k]));
        chk(w_data[k] == ed[k], (k < 6) ? "R4 write data" : "R5 R6 write data",
            32'(w_data[k]), 32'(ed[k]));
        chk(w_arr[k] == (k == 6), "R5 array port used only for data word",
            32'(w_arr[k]), 32'(k == 6));
      end
      chk(w_prog[6] == v.space, "R5 space flag on array write",
          32'(w_prog[6]), 32'(v.space));
    end
    @(negedge clk);
    chk(!done, "R7 done one cycle", 32'(done), 0);
    chk(!bus_rd && !bus_wr && !arr_wr && !busy, "R1 quiet after done",
        32'({busy, bus_rd, bus_wr, arr_wr}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !bus_rd && !bus_wr && !arr_wr, "R1 reset controls",
        32'({busy, done, bus_rd, bus_wr, arr_wr}), 0);
    chk(final_status == 0 && !exec_err && !timeout, "R1 reset results",
        32'({final_status, exec_err, timeout}), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(!busy && !bus_rd, "R1 idle without start", 32'({busy, bus_rd}), 0);

    for (int n = 0; n < NVEC; n++) run_vec(VECS[n], 1);

    // R10: start held high for several cycles launches only one run
    run_vec(VECS[0], 4);
    chk(nwrites == 9, "R10 start ignored while busy", 32'(nwrites), 9);
    repeat (5) @(negedge clk);
    chk(!busy && !bus_rd, "R10 no second run", 32'({busy, bus_rd}), 0);

    // reset in the middle of a run returns to idle
    clear_model(VECS[2]);
    launch(VECS[2], 1);
    repeat (6) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !bus_rd && !bus_wr && !arr_wr, "R1 reset aborts run",
        32'({busy, bus_rd, bus_wr, arr_wr}), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule